// File: doc/BRIEF.md
# Strobe-Driven External FIFO Bus Master

This block sits in a synchronous design and moves bytes to and from an external parallel FIFO device that is controlled only by level status flags and strobes. The device shares one 8-bit data bus between both directions. It reports with two active-low flags whether a byte is waiting to be read and whether there is room to write. Reading is done by pulling an active-low read strobe, and writing by raising and then dropping a write strobe whose falling edge latches the bus. Every analog limit on pulse width, data access time, setup, hold and flag recovery is met by holding each strobe phase for a number of clock cycles that is derived from nanosecond parameters and the clock period.

On the user side, received bytes come out as a valid/ready stream, and bytes to transmit go in as a valid/ready stream through a one-byte holding slot. The block drives the shared bus only while it writes. It keeps at least one cycle with no driver on the bus whenever the transfer direction changes. Both status flags pass through a two-flop synchroniser. After each strobe, the flag of that direction is ignored for long enough that a stale level can no longer be mistaken for a new one. When both directions are ready, the grant alternates between them.

Top module: `ebm_master`

## Requirements
- R1: While reset is high and in the first cycle after it, the read strobe is high, the write strobe is low, the bus drivers are off, no received byte is offered and the transmit slot reports ready.
- R2: A read strobe begins only when the synchronised receive flag is low (low meaning a byte waits). After each read the flag is disregarded for SYNC_STAGES + ceil(FLAG_SETTLE_NS/CLK_NS) + 1 cycles, so an empty device (flag high) is never read.
- R3: The read strobe stays low for ceil(RD_ACCESS_NS/CLK_NS) cycles. The bus is captured on the final cycle of that low phase, so the byte the device presents 50 ns after the strobe falls is the one delivered, and bytes are delivered in device order.
- R4: A received byte stays offered with unchanged value until it is accepted with rx_ready. No further read is started while it is unaccepted, so under back-pressure no byte is lost.
- R5: A write starts only when the synchronised transmit flag is low (low meaning space). The device is never written while that flag is high, and a write held back this way goes out once the flag returns low.
- R6: During a write the data is driven from the cycle the write strobe rises. The strobe stays high long enough for both the 10 ns pulse and the 20 ns setup before its falling edge. Data and driver enable are held at least 10 ns after the fall, and the next rise comes no sooner than 50 ns after the previous fall.
- R7: tx_ready is high exactly when the one-byte transmit slot is empty. Accepted bytes reach the device in acceptance order.
- R8: The bus drivers are enabled only during a write. No read strobe is low while they are enabled, and at least one cycle with neither a read strobe nor enabled drivers separates transfers in opposite directions.
- R9: When reading and writing are both possible in the same cycle, the grant goes to the direction not served last. Under sustained load in both directions, transfers therefore alternate read, write, read, write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rxav_n | input | 1 | Device flag, low while a byte can be read (asynchronous) |
| ext_txsp_n | input | 1 | Device flag, low while a byte can be written (asynchronous) |
| ext_rd_n | output | 1 | Active-low read strobe to the device |
| ext_wr | output | 1 | Write strobe; the device latches on its falling edge |
| bus_in | input | DW | Data bus as seen at the pins |
| bus_out | output | DW | Data this block drives onto the bus |
| bus_oe | output | 1 | Enable of this block's bus drivers |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | Received byte is offered |
| rx_ready | input | 1 | User accepts the received byte |
| tx_data | input | DW | Byte to transmit |
| tx_valid | input | 1 | Byte to transmit is offered |
| tx_ready | output | 1 | Transmit slot is empty |

## Verification
A read grant and a write grant can both be eligible in the same idle cycle, and then the arbiter and the turnaround idle must act together. The bench provokes this by filling the device model's receive queue and streaming transmit bytes at once. It then judges the order of completed strobes, which must alternate, while timing-annotated device models check the turnaround gap, the sample point and the write setup and hold on every transfer. Flag recovery after a strobe can coincide with a grant of the other direction; the flag-gated strobe checks catch a stale flag being trusted.

// File: rtl/ebm_pkg.sv
`timescale 1ns/1ps
package ebm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_RD    = 3'd2,
    ST_WHI   = 3'd3,
    ST_WHOLD = 3'd4
  } ebm_state_e;

  // nanoseconds rounded up to whole clock cycles
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ebm_sync.sv
`timescale 1ns/1ps
module ebm_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ebm_recovery.sv
`timescale 1ns/1ps
// Hold-off timer: after a strobe ends, the matching status flag is not
// trusted for LEN cycles.
module ebm_recovery #(
  parameter int unsigned LEN = 5,
  parameter int unsigned CW  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (start)          left_q <= CW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/ebm_arbiter.sv
`timescale 1ns/1ps
// Two-way alternating grant. last_wr remembers the direction served last.
module ebm_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic rd_ok,
  input  logic wr_ok,
  input  logic take,
  output logic gnt_rd,
  output logic gnt_wr
);

  logic last_wr;

  always_comb begin
    gnt_rd = 1'b0;
    gnt_wr = 1'b0;
    if (rd_ok && wr_ok) begin
      gnt_wr = !last_wr;
      gnt_rd = last_wr;
    end else begin
      gnt_rd = rd_ok;
      gnt_wr = wr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_wr <= 1'b0;
    else if (take) last_wr <= gnt_wr;
  end

endmodule

// File: rtl/ebm_master.sv
`timescale 1ns/1ps
module ebm_master
  import ebm_pkg::*;
#(
  parameter int unsigned DW             = 8,
  parameter int unsigned CLK_NS         = 20,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned RD_ACCESS_NS   = 50,
  parameter int unsigned WR_SETUP_NS    = 20,
  parameter int unsigned WR_PULSE_NS    = 10,
  parameter int unsigned WR_HOLD_NS     = 10,
  parameter int unsigned WR_GAP_NS      = 50,
  parameter int unsigned FLAG_SETTLE_NS = 25,
  parameter int unsigned TURN_CYC       = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_rxav_n,
  input  logic          ext_txsp_n,
  output logic          ext_rd_n,
  output logic          ext_wr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready
);

  // phase lengths in cycles
  localparam int unsigned RD_ACT   = at_least_one(ns_to_cyc(RD_ACCESS_NS, CLK_NS));
  localparam int unsigned WR_HI    = at_least_one(max2(ns_to_cyc(WR_PULSE_NS, CLK_NS),
                                                       ns_to_cyc(WR_SETUP_NS, CLK_NS)));
  localparam int unsigned WR_HLD   = at_least_one(ns_to_cyc(WR_HOLD_NS, CLK_NS));
  localparam int unsigned TURN_LEN = at_least_one(TURN_CYC);
  localparam int unsigned REC_BASE = SYNC_STAGES + ns_to_cyc(FLAG_SETTLE_NS, CLK_NS) + 1;
  localparam int unsigned RD_REC   = REC_BASE;
  localparam int unsigned WR_REC   = max2(REC_BASE, ns_to_cyc(WR_GAP_NS, CLK_NS));
  localparam int unsigned MAX_LEN  = max2(max2(max2(RD_ACT, WR_HI), max2(WR_HLD, TURN_LEN)),
                                          max2(RD_REC, WR_REC));
  localparam int unsigned CW       = $clog2(MAX_LEN + 1);

  // ---------------- status flag synchronisation ----------------
  logic [1:0] flags_s;
  logic       rxav_s, txsp_s;

  ebm_sync #(
    .WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)
  ) u_sync (
    .clk(clk), .rst(rst), .din({ext_txsp_n, ext_rxav_n}), .dout(flags_s)
  );

  assign rxav_s = flags_s[0];
  assign txsp_s = flags_s[1];

  // ---------------- state ----------------
  ebm_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_wr_q, pend_wr_n;
  logic          dir_wr_q;

  logic [DW-1:0] rx_q;
  logic          rxv_q;
  logic [DW-1:0] tx_buf_q;
  logic          tx_full_q;

  logic          rd_n_q, wr_q, oe_q;
  logic [DW-1:0] dout_q;

  // ---------------- eligibility and arbitration ----------------
  logic rd_busy, wr_busy;
  logic rd_ok, wr_ok, gnt_rd, gnt_wr, take;
  logic rd_done, wr_fall;

  assign rd_ok = !rxav_s && !rd_busy && !rxv_q;
  assign wr_ok = tx_full_q && !txsp_s && !wr_busy;
  assign take  = (state_q == ST_IDLE) && (gnt_rd || gnt_wr);

  ebm_arbiter u_arb (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .wr_ok(wr_ok), .take(take),
    .gnt_rd(gnt_rd), .gnt_wr(gnt_wr)
  );

  assign rd_done = (state_q == ST_RD)  && (cnt_q == '0);
  assign wr_fall = (state_q == ST_WHI) && (cnt_q == '0);

  ebm_recovery #(.LEN(RD_REC), .CW(CW)) u_rd_rec (
    .clk(clk), .rst(rst), .start(rd_done), .busy(rd_busy)
  );

  ebm_recovery #(.LEN(WR_REC), .CW(CW)) u_wr_rec (
    .clk(clk), .rst(rst), .start(wr_fall), .busy(wr_busy)
  );

  // ---------------- phase sequencer ----------------
  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    pend_wr_n = pend_wr_q;
    case (state_q)
      ST_IDLE: begin
        if (gnt_rd) begin
          if (dir_wr_q) begin
            state_n   = ST_TURN;
            cnt_n     = CW'(TURN_LEN - 1);
            pend_wr_n = 1'b0;
          end else begin
            state_n = ST_RD;
            cnt_n   = CW'(RD_ACT - 1);
          end
        end else if (gnt_wr) begin
          if (!dir_wr_q) begin
            state_n   = ST_TURN;
            cnt_n     = CW'(TURN_LEN - 1);
            pend_wr_n = 1'b1;
          end else begin
            state_n = ST_WHI;
            cnt_n   = CW'(WR_HI - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) begin
          if (pend_wr_q) begin
            state_n = ST_WHI;
            cnt_n   = CW'(WR_HI - 1);
          end else begin
            state_n = ST_RD;
            cnt_n   = CW'(RD_ACT - 1);
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_RD: begin
        if (cnt_q == '0) state_n = ST_IDLE;
        else             cnt_n   = cnt_q - 1'b1;
      end
      ST_WHI: begin
        if (cnt_q == '0) begin
          state_n = ST_WHOLD;
          cnt_n   = CW'(WR_HLD - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt_q == '0) state_n = ST_IDLE;
        else             cnt_n   = cnt_q - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  logic enter_rd, enter_whi;
  assign enter_rd  = (state_n == ST_RD)  && (state_q != ST_RD);
  assign enter_whi = (state_n == ST_WHI) && (state_q != ST_WHI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pend_wr_q <= 1'b0;
      dir_wr_q  <= 1'b0;
      rd_n_q    <= 1'b1;
      wr_q      <= 1'b0;
      oe_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      pend_wr_q <= pend_wr_n;
      if (enter_rd)  dir_wr_q <= 1'b0;
      if (enter_whi) dir_wr_q <= 1'b1;
      // pin registers follow the next phase so they change cleanly on the edge
      rd_n_q <= (state_n != ST_RD);
      wr_q   <= (state_n == ST_WHI);
      oe_q   <= (state_n == ST_WHI) || (state_n == ST_WHOLD);
      if (enter_whi) dout_q <= tx_buf_q;
    end
  end

  // ---------------- user-side slots ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= '0;
      rxv_q <= 1'b0;
    end else begin
      if (rd_done) begin
        rx_q  <= bus_in;
        rxv_q <= 1'b1;
      end else if (rxv_q && rx_ready) begin
        rxv_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
    end else begin
      if (tx_valid && !tx_full_q) begin
        tx_buf_q  <= tx_data;
        tx_full_q <= 1'b1;
      end else if (enter_whi) begin
        tx_full_q <= 1'b0;
      end
    end
  end

  assign ext_rd_n = rd_n_q;
  assign ext_wr   = wr_q;
  assign bus_oe   = oe_q;
  assign bus_out  = dout_q;
  assign rx_data  = rx_q;
  assign rx_valid = rxv_q;
  assign tx_ready = !tx_full_q;

endmodule

// File: rtl/ebm_master_chk.sv
`timescale 1ns/1ps
module ebm_master_chk #(
  parameter int unsigned DW         = 8,
  parameter int unsigned RD_ACT_MIN = 3,
  parameter int unsigned CW         = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_rd_n,
  input logic          ext_wr,
  input logic          bus_oe,
  input logic          ext_rxav_n,
  input logic          ext_txsp_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data
);

  logic [CW-1:0] rd_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   rd_low_cnt <= '0;
    else if (ext_rd_n)         rd_low_cnt <= '0;
    else if (rd_low_cnt != '1) rd_low_cnt <= rd_low_cnt + 1'b1;
  end

  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ext_rd_n);

  a_r8_gap_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(ext_rd_n));

  a_r8_gap_after_write: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_rd_n) |-> !$past(bus_oe));

  a_r2_read_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_rd_n) |-> !$past(ext_rxav_n, 3));

  a_r5_write_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_wr) |-> !$past(ext_txsp_n, 3));

  a_r3_strobe_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_rd_n) |-> (rd_low_cnt >= CW'(RD_ACT_MIN)));

  a_r6_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_wr) |-> bus_oe);

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

endmodule

bind ebm_master ebm_master_chk #(
  .DW(DW), .RD_ACT_MIN(RD_ACT), .CW(8)
) u_chk (
  .clk(clk), .rst(rst), .ext_rd_n(ext_rd_n), .ext_wr(ext_wr), .bus_oe(bus_oe),
  .ext_rxav_n(ext_rxav_n), .ext_txsp_n(ext_txsp_n),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/ebm_master_tb.sv
`timescale 1ns/1ps
module ebm_master_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_rxav_n = 1'b1;
  logic       ext_txsp_n = 1'b0;
  logic [7:0] bus_in = 8'hEE;
  logic       ext_rd_n, ext_wr, bus_oe, rx_valid, tx_ready;
  logic [7:0] bus_out, rx_data;
  logic       rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;

  always #10 clk = ~clk;

  ebm_master u_dut (
    .clk(clk), .rst(rst), .ext_rxav_n(ext_rxav_n), .ext_txsp_n(ext_txsp_n),
    .ext_rd_n(ext_rd_n), .ext_wr(ext_wr), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- external device model: receive side ----------------
  byte unsigned rxq[$];
  byte unsigned exp_rx[$];
  byte unsigned rxlog[$];
  bit           oplog[$];   // 0 = read completed, 1 = write latched
  bit           rd_recov = 0;
  int           rd_falls = 0;

  task automatic push_rx(input byte unsigned b);
    rxq.push_back(b);
    exp_rx.push_back(b);
    if (!rd_recov) ext_rxav_n = 1'b0;
  endtask

  always @(negedge ext_rd_n) begin
    if (!rst) begin
      rd_falls++;
      chk(rxq.size() != 0, "R2 read strobe while device empty", 0, 1);
      bus_in = 8'hEE;
      #50;
      if (!ext_rd_n) bus_in = (rxq.size() != 0) ? rxq[0] : 8'hEE;
    end
  end

  always @(posedge ext_rd_n) begin
    if (!rst) begin
      if (rxq.size() != 0) void'(rxq.pop_front());
      oplog.push_back(1'b0);
      rd_recov = 1;
      bus_in   = 8'hEE;
      #20 ext_rxav_n = 1'b1;
      #67;
      rd_recov   = 0;
      ext_rxav_n = (rxq.size() == 0);
    end
  end

  // ---------------- external device model: transmit side ----------------
  byte unsigned txlog[$];
  byte unsigned exp_tx[$];
  int           tx_space = 1000;
  realtime      t_dchg = -1.0e6;
  realtime      t_wrise = -1.0e6;
  realtime      t_wfall = -1.0e6;

  always @(bus_out or bus_oe) begin
    if (!rst) begin
      if ($realtime - t_wfall < 10.0)
        chk(0, "R6 data or enable changed inside hold time", int'($realtime - t_wfall), 10);
      t_dchg = $realtime;
    end
  end

  always @(posedge ext_wr) begin
    if (!rst) begin
      chk($realtime - t_wfall >= 50.0, "R6 write precharge", int'($realtime - t_wfall), 50);
      t_wrise = $realtime;
    end
  end

  always @(negedge ext_wr) begin
    if (!rst) begin
      chk(bus_oe, "R8 drivers on at write latch", bus_oe, 1);
      chk(ext_txsp_n == 1'b0, "R5 write while device full", ext_txsp_n, 0);
      chk($realtime - t_dchg >= 20.0, "R6 data setup", int'($realtime - t_dchg), 20);
      chk($realtime - t_wrise >= 10.0, "R6 strobe width", int'($realtime - t_wrise), 10);
      txlog.push_back(bus_out);
      oplog.push_back(1'b1);
      t_wfall = $realtime;
      tx_space--;
      #15 ext_txsp_n = 1'b1;
      #70 ext_txsp_n = (tx_space <= 0);
    end
  end

  // ---------------- turnaround gap observer (mid-cycle) ----------------
  logic prev_oe = 1'b0;
  logic prev_rdn = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_oe && !prev_oe)
        chk(prev_rdn && ext_rd_n, "R8 no idle cycle before driving", prev_rdn, 1);
      if (!ext_rd_n && prev_rdn)
        chk(!prev_oe && !bus_oe, "R8 no idle cycle before reading", prev_oe, 0);
    end
    prev_oe  = bus_oe;
    prev_rdn = ext_rd_n;
  end

  // ---------------- user side ----------------
  bit bp_mode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    rx_ready = bp_mode ? ((cyc % 4) == 3) : 1'b1;
  end

  bit           stall_prev = 0;
  byte unsigned stall_data = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (stall_prev)
        chk(rx_valid && rx_data == stall_data, "R4 offered byte changed while stalled",
            rx_data, stall_data);
      if (rx_valid && rx_ready) rxlog.push_back(rx_data);
      stall_prev = rx_valid && !rx_ready;
      stall_data = rx_data;
    end
  end

  task automatic send_tx(input byte unsigned b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    exp_tx.push_back(b);
    forever begin
      @(posedge clk);
      if (tx_ready) break;
    end
  endtask

  task automatic tx_idle();
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_counts(input int nrx, input int ntx);
    for (int i = 0; i < 20000; i++) begin
      if (rxlog.size() >= nrx && txlog.size() >= ntx) break;
      @(posedge clk);
    end
  endtask

  task automatic compare_rx(input string req);
    chk(rxlog.size() == exp_rx.size(), req, rxlog.size(), exp_rx.size());
    for (int i = 0; i < exp_rx.size() && i < rxlog.size(); i++)
      chk(rxlog[i] == exp_rx[i], req, rxlog[i], exp_rx[i]);
  endtask

  task automatic compare_tx(input string req);
    chk(txlog.size() == exp_tx.size(), req, txlog.size(), exp_tx.size());
    for (int i = 0; i < exp_tx.size() && i < txlog.size(); i++)
      chk(txlog[i] == exp_tx[i], req, txlog[i], exp_tx[i]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(posedge clk);
    // R1: state while still in reset
    @(negedge clk);
    chk(ext_rd_n == 1'b1, "R1 read strobe in reset", ext_rd_n, 1);
    chk(bus_oe == 1'b0, "R1 drivers in reset", bus_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ext_rd_n == 1'b1, "R1 read strobe idle", ext_rd_n, 1);
    chk(ext_wr == 1'b0, "R1 write strobe idle", ext_wr, 0);
    chk(bus_oe == 1'b0, "R1 drivers off", bus_oe, 0);
    chk(rx_valid == 1'b0, "R1 nothing offered", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1 slot empty", tx_ready, 1);

    // R3: read sweep, bytes must match device order and the 50 ns sample point
    for (int i = 0; i < 40; i++) push_rx(byte'(i * 37 + 5));
    wait_counts(40, 0);
    compare_rx("R3 read sweep");

    // R4: back-pressure, no byte lost or altered
    bp_mode = 1;
    for (int i = 0; i < 12; i++) push_rx(byte'(8'hC0 ^ (i * 19)));
    wait_counts(52, 0);
    repeat (10) @(posedge clk);
    bp_mode = 0;
    compare_rx("R4 back-pressure read");

    // R7/R6: write sweep
    for (int i = 0; i < 40; i++) send_tx(byte'(i * 53 + 11));
    tx_idle();
    wait_counts(52, 40);
    compare_tx("R7 write sweep order");

    // R5 and R2: device full and empty at once, nothing may move
    repeat (20) @(posedge clk);
    tx_space   = 0;
    ext_txsp_n = 1'b1;
    begin
      int n_tx;
      int n_rd;
      n_tx = txlog.size();
      n_rd = rd_falls;
      send_tx(8'hA5);
      tx_idle();
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(txlog.size() == n_tx, "R5 write held while device full", txlog.size(), n_tx);
      chk(rd_falls == n_rd, "R2 no read while device empty", rd_falls, n_rd);
      chk(tx_ready == 1'b0, "R7 slot reports full", tx_ready, 0);
      tx_space   = 1000;
      ext_txsp_n = 1'b0;
      wait_counts(52, n_tx + 1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(txlog.size() == n_tx + 1, "R5 held write released", txlog.size(), n_tx + 1);
      chk(txlog[txlog.size()-1] == 8'hA5, "R5 held byte value", txlog[txlog.size()-1], 8'hA5);
      chk(tx_ready == 1'b1, "R7 slot empty again", tx_ready, 1);
    end

    // R9: both directions loaded at once must alternate
    repeat (20) @(posedge clk);
    oplog.delete();
    for (int i = 0; i < 16; i++) push_rx(byte'(i * 11 + 3));
    for (int i = 0; i < 16; i++) send_tx(byte'(8'h5A + i * 29));
    tx_idle();
    wait_counts(68, 57);
    repeat (20) @(posedge clk);
    chk(oplog.size() == 32, "R9 transfer count", oplog.size(), 32);
    for (int i = 1; i < oplog.size(); i++)
      chk(oplog[i] != oplog[i-1], "R9 directions alternate", oplog[i], !oplog[i-1]);
    compare_rx("R9 concurrent read data");
    compare_tx("R9 concurrent write data");

    finish_up();
  end

endmodule